// File: doc/BRIEF.md
# Processor Mode Control Register

This block holds one byte of processor configuration that the CPU reaches through a write port and a read port at a single fixed address. Each bit has its own write rule. Four bits take their reset value from a mode-strap input. Two pin-enable bits lock at zero once software clears them while an external bus is in use. The direct-page switch bit may change value only once after each reset.

The block also takes the operating mode as an input. From the mode and the stored byte it drives the configuration outputs:

- the selects that hand port pins over to the ready, address-latch and hold/acknowledge bus signals;
- the number of recovery cycles to insert on external accesses;
- the bus-cycle choice for external accesses outside the chip-select areas;
- the access length of the internal program memory.

The write and read ports are plain control signals with no handshake. A write is taken on the clock edge where chip-select, write-enable and the address match are all high together. The block never stalls the CPU, so it applies no back-pressure.

Top module: `pmode_cfg_reg`

## Requirements
- R1: During a synchronous reset (rst_n low at a clock edge) the stored byte becomes 0 in bits 0, 4, 6 and 7. Bits 1 (ready enable), 2 (address-latch enable), 3 (hold/acknowledge enable) and 5 (recovery insert) each take the value of `mode_strap`.
- R2: The stored byte changes only at a clock edge where `cs`, `wr_en` are high and `addr` equals 0x5F. A write with any of these missing leaves every bit unchanged.
- R3: While `cs` is high and `addr` is 0x5F, `rdata` shows the stored byte, including bits the current mode ignores. Otherwise `rdata` is 0.
- R4: In op_mode 01 (memory expansion) or 10 (microprocessor), a write of 0 to bit 1 or bit 3 while that bit holds 1 clears the bit and locks it. Later writes of 1 to a locked bit are ignored until reset. In op_mode 00 or 11 these bits are freely writable unless they are already locked.
- R5: Bit 4 (direct-page switch) may change value at most once after reset. Writes that would change it again are ignored. Writes that keep its value do not use up the single change.
- R6: `rdy_pin_sel`, `ale_pin_sel` and `hold_pin_sel` equal bits 1, 2 and 3 when op_mode is 01 or 10. They are 0 in op_mode 00 (single-chip) and 11.
- R7: `rcv_cycles` is 0 unless op_mode is 01 or 10 and bit 5 is 1. In that case it is 1 when bit 6 is 0 and 2 when bit 6 is 1.
- R8: `rom_clocks` is 3 when bit 7 is 0 and 2 when bit 7 is 1. It is 0 in op_mode 10, where internal program memory is not used.
- R9: `ext_bus_sel` follows bit 0 and `dpr_quad` follows bit 4 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_strap | input | 1 | Strap level that sets the reset value of bits 1, 2, 3 and 5 |
| op_mode | input | 2 | 00 single-chip, 01 memory expansion, 10 microprocessor, 11 treated as single-chip |
| cs | input | 1 | Register-space chip select |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | CPU address within the register space |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not addressed |
| rdy_pin_sel | output | 1 | Hands the ready pin to the bus |
| ale_pin_sel | output | 1 | Hands the address-latch pin to the bus |
| hold_pin_sel | output | 1 | Hands the hold input and acknowledge output pins to the bus |
| rcv_cycles | output | 2 | Recovery cycles for external accesses (0, 1 or 2) |
| ext_bus_sel | output | 1 | Bus-cycle choice for external areas outside chip-select areas |
| dpr_quad | output | 1 | 1 = four direct-page registers, 0 = one |
| rom_clocks | output | 2 | Internal program memory access length in clocks (3, 2, or 0 when unused) |

## Verification
Random writes run across all four mode codes and both strap levels, with occasional resets. This separates mode-gated outputs from stored values, because the same byte must read back unchanged while the pin selects and recovery count drop to zero in single-chip mode.

Directed sequences target specific behaviours:
- A clear followed by a set in expansion mode tells the clear-only lock apart from a plain bit.
- The same pair in single-chip mode shows that no lock forms there.
- Alternating writes to bit 4 show the single change allowed to the direct-page switch.
- Writes with a wrong address, with chip-select low, or with the strobe low show that only the full match writes.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  typedef enum logic [1:0] {
    OPM_SINGLE = 2'b00,
    OPM_EXPAND = 2'b01,
    OPM_MPU    = 2'b10,
    OPM_RSVD   = 2'b11
  } opmode_e;

  localparam int CFG_W      = 8;
  localparam int B_EXTBUS   = 0;
  localparam int B_RDY      = 1;
  localparam int B_ALE      = 2;
  localparam int B_HOLD     = 3;
  localparam int B_DPR      = 4;
  localparam int B_RCV_ON   = 5;
  localparam int B_RCV_TWO  = 6;
  localparam int B_ROM_FAST = 7;

  function automatic logic uses_ext_bus(opmode_e m);
    return (m == OPM_EXPAND) || (m == OPM_MPU);
  endfunction
endpackage

// File: rtl/pmode_store.sv
module pmode_store
  import pmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap,
  input  logic             ext_mode,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  for (genvar b = 0; b < CFG_W; b++) begin : g_bit
    localparam bit STRAP_RST = (b == B_RDY) || (b == B_ALE) ||
                               (b == B_HOLD) || (b == B_RCV_ON);
    logic bit_q;
    assign q[b] = bit_q;

    if (b == B_RDY || b == B_HOLD) begin : g_clear_only
      logic lock_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bit_q  <= strap;
          lock_q <= 1'b0;
        end else if (wr) begin
          if (ext_mode && bit_q && !wdata[b]) lock_q <= 1'b1;
          if (!(lock_q && wdata[b])) bit_q <= wdata[b];
        end
      end
      // R4
      lock_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> !bit_q);
    end else if (b == B_DPR) begin : g_once
      logic used_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bit_q  <= 1'b0;
          used_q <= 1'b0;
        end else if (wr && !used_q && (wdata[b] != bit_q)) begin
          bit_q  <= wdata[b];
          used_q <= 1'b1;
        end
      end
      // R5
      dpr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_q |=> $stable(bit_q));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)  bit_q <= STRAP_RST ? strap : 1'b0;
        else if (wr) bit_q <= wdata[b];
      end
    end
  end
endmodule

// File: rtl/pmode_outmap.sv
module pmode_outmap
  import pmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  opmode_e          mode,
  input  logic [CFG_W-1:0] q,
  output logic             rdy_sel,
  output logic             ale_sel,
  output logic             hold_sel,
  output logic [1:0]       rcv_cycles,
  output logic             ext_bus_sel,
  output logic             dpr_quad,
  output logic [1:0]       rom_clocks
);
  logic ext;
  assign ext = uses_ext_bus(mode);

  always_comb begin
    rdy_sel     = ext & q[B_RDY];
    ale_sel     = ext & q[B_ALE];
    hold_sel    = ext & q[B_HOLD];
    ext_bus_sel = q[B_EXTBUS];
    dpr_quad    = q[B_DPR];
    if (ext && q[B_RCV_ON]) rcv_cycles = q[B_RCV_TWO] ? 2'd2 : 2'd1;
    else                    rcv_cycles = 2'd0;
    if (mode == OPM_MPU)    rom_clocks = 2'd0;
    else                    rom_clocks = q[B_ROM_FAST] ? 2'd2 : 2'd3;
  end

  // R6
  single_chip_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext |-> !(rdy_sel || ale_sel || hold_sel));
  // R7
  rcv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_cycles != 2'd3);
  // R7
  rcv_single_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext |-> rcv_cycles == 2'd0);
  // R8
  rom_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OPM_MPU) |-> rom_clocks == 2'd0);
endmodule

// File: rtl/pmode_cfg_reg.sv
module pmode_cfg_reg
  import pmode_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h5F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_strap,
  input  logic [1:0]        op_mode,
  input  logic              cs,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdy_pin_sel,
  output logic              ale_pin_sel,
  output logic              hold_pin_sel,
  output logic [1:0]        rcv_cycles,
  output logic              ext_bus_sel,
  output logic              dpr_quad,
  output logic [1:0]        rom_clocks
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  opmode_e          mode;
  logic             hit, wr;
  logic [CFG_W-1:0] cfg_q;

  assign mode  = opmode_e'(op_mode);
  assign hit   = cs && (addr == MY_ADDR);
  assign wr    = hit && wr_en;
  assign rdata = hit ? cfg_q : '0;

  pmode_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap    (mode_strap),
    .ext_mode (uses_ext_bus(mode)),
    .wr       (wr),
    .wdata    (wdata),
    .q        (cfg_q)
  );

  pmode_outmap u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .q           (cfg_q),
    .rdy_sel     (rdy_pin_sel),
    .ale_sel     (ale_pin_sel),
    .hold_sel    (hold_pin_sel),
    .rcv_cycles  (rcv_cycles),
    .ext_bus_sel (ext_bus_sel),
    .dpr_quad    (dpr_quad),
    .rom_clocks  (rom_clocks)
  );

  // R2
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr_en && addr == MY_ADDR) |=> $stable(cfg_q));
endmodule

// File: tb/pmode_cfg_reg_bench.sv
`timescale 1ns/1ps
module pmode_cfg_reg_bench;
  localparam logic [7:0] RA = 8'h5F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, mode_strap = 1'b0;
  logic [1:0] op_mode = 2'b00;
  logic       cs = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic       rdy_pin_sel, ale_pin_sel, hold_pin_sel, ext_bus_sel, dpr_quad;
  logic [1:0] rcv_cycles, rom_clocks;

  always #2.5 clk = ~clk;

  pmode_cfg_reg u_pmode_cfg_reg (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .op_mode(op_mode),
    .cs(cs), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdy_pin_sel(rdy_pin_sel), .ale_pin_sel(ale_pin_sel),
    .hold_pin_sel(hold_pin_sel), .rcv_cycles(rcv_cycles),
    .ext_bus_sel(ext_bus_sel), .dpr_quad(dpr_quad), .rom_clocks(rom_clocks)
  );

  int checks = 0, errors = 0;
  logic [7:0] mq = 8'h00;
  bit lk_rdy = 0, lk_hold = 0, dused = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit ext_m(logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic int exp_rcv(logic [1:0] m, logic [7:0] v);
    if (ext_m(m) && v[5]) return v[6] ? 2 : 1;
    return 0;
  endfunction

  function automatic int exp_rom(logic [1:0] m, logic [7:0] v);
    if (m == 2'b10) return 0;
    return v[7] ? 2 : 3;
  endfunction

  task automatic model_write(logic [7:0] d, logic [1:0] m);
    bit ol_r = lk_rdy, ol_h = lk_hold;
    if (ext_m(m) && mq[1] && !d[1]) lk_rdy = 1;
    if (ext_m(m) && mq[3] && !d[3]) lk_hold = 1;
    if (!(ol_r && d[1])) mq[1] = d[1];
    if (!(ol_h && d[3])) mq[3] = d[3];
    if (!dused && d[4] != mq[4]) begin mq[4] = d[4]; dused = 1; end
    mq[0] = d[0]; mq[2] = d[2]; mq[5] = d[5]; mq[6] = d[6]; mq[7] = d[7];
  endtask

  task automatic check_outs();
    // R3 read data
    chk("R3", "rdata", rdata, (cs && addr == RA) ? mq : 8'h00);
    // R6 pin selects
    chk("R6", "rdy_pin_sel", rdy_pin_sel, ext_m(op_mode) & mq[1]);
    chk("R6", "ale_pin_sel", ale_pin_sel, ext_m(op_mode) & mq[2]);
    chk("R6", "hold_pin_sel", hold_pin_sel, ext_m(op_mode) & mq[3]);
    // R7 recovery count
    chk("R7", "rcv_cycles", rcv_cycles, exp_rcv(op_mode, mq));
    // R8 rom length
    chk("R8", "rom_clocks", rom_clocks, exp_rom(op_mode, mq));
    // R9 pass-through bits
    chk("R9", "ext_bus_sel", ext_bus_sel, mq[0]);
    chk("R9", "dpr_quad", dpr_quad, mq[4]);
  endtask

  task automatic do_reset(bit s);
    @(negedge clk);
    rst_n = 0; mode_strap = s; cs = 0; wr_en = 0;
    @(posedge clk); @(posedge clk);
    mq = {2'b00, s, 1'b0, s, s, s, 1'b0};
    lk_rdy = 0; lk_hold = 0; dused = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic cycle(bit c, bit w, logic [7:0] a, logic [7:0] d, logic [1:0] m);
    @(negedge clk);
    cs = c; wr_en = w; addr = a; wdata = d; op_mode = m;
    #1 check_outs();
    @(posedge clk);
    if (c && w && a == RA) model_write(d, m);
  endtask

  task automatic read_chk(string req, logic [7:0] exp);
    @(negedge clk);
    cs = 1; wr_en = 0; addr = RA;
    #1 chk(req, "stored byte", rdata, exp);
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h0000_5EED);
    // R1 strap high
    do_reset(1'b1);
    read_chk("R1", 8'h2E);
    cycle(0, 0, 8'h00, 8'h00, 2'b01);
    cycle(0, 0, 8'h00, 8'h00, 2'b00);   // R6 gating in single-chip
    // R4 lock in expansion mode, R5 single change of bit 4
    cycle(1, 1, RA, 8'h00, 2'b01);
    cycle(1, 1, RA, 8'hFF, 2'b01);
    read_chk("R4", 8'hF5);
    cycle(1, 1, RA, 8'h00, 2'b10);
    read_chk("R5", 8'h10);
    // R1 strap low, then no lock in single-chip mode
    do_reset(1'b0);
    read_chk("R1", 8'h00);
    cycle(1, 1, RA, 8'h0A, 2'b00);
    cycle(1, 1, RA, 8'h00, 2'b00);
    cycle(1, 1, RA, 8'h0A, 2'b00);
    read_chk("R4", 8'h0A);
    // R2 incomplete write qualifiers
    cycle(1, 1, 8'h5E, 8'hFF, 2'b01);
    cycle(0, 1, RA, 8'hFF, 2'b01);
    cycle(1, 0, RA, 8'hFF, 2'b01);
    read_chk("R2", 8'h0A);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 100) == 0) do_reset(1'($urandom));
      cycle(($urandom % 4) != 0, 1'($urandom),
            (($urandom % 10) < 7) ? RA : 8'($urandom),
            8'($urandom), 2'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule